// File: doc/BRIEF.md
# Packet-Counting Bulk IN Transmit FIFO

This block is the transmit buffer of a device-to-host bulk endpoint. A processor-side port loads bytes one at a time into one of two 64-byte packet slots, which are filled and drained in ping-pong order. A slot becomes a queued packet either when its 64th byte arrives or when software raises the short-packet strobe, which closes the slot at whatever length it has reached, zero included. Until then the slot is a partial packet: it is neither counted nor offered to the reader.

The serial-engine side sees the oldest queued packet. It gets a valid flag, the packet length (0 to 64) and a random-access byte read port. A one-cycle packet-sent pulse releases that slot. A service-request output stays high while at most one complete packet is queued, so software knows it may load another. Bytes written while both slots are full are discarded and raise a sticky overflow flag. A flush pulse empties everything, partial data included, and clears the overflow flag.

Top module: `bulkin_txq`

## Requirements
- R1: After reset, svc_req is 1, rd_valid is 0 and overflow is 0.
- R2: When the 64th byte is written into the current slot, that slot becomes a queued packet with rd_len equal to 64 (7-bit length field). The change is visible in the cycle after the write edge.
- R3: A short_pkt strobe closes the current slot with length equal to the bytes already loaded. A byte written with wr_en in the same cycle is included in that length.
- R4: A short_pkt strobe with no bytes loaded in the current slot queues a zero-length packet: rd_valid becomes 1 with rd_len 0.
- R5: A partially filled slot that has not been closed is not counted. rd_valid stays 0 while it is the only data held, and svc_req stays 1.
- R6: svc_req is 1 while zero or one complete packets are queued and 0 while two are queued.
- R7: Packets are presented oldest first. With rd_valid high, rd_data shows byte rd_addr (0 = first byte written) of the head packet. A pkt_sent pulse releases the head, and the next packet becomes the head in the following cycle.
- R8: wr_en while two complete packets are queued stores nothing and sets overflow in the next cycle. overflow then stays 1 until flush, and the queued packets are unchanged.
- R9: A flush pulse discards queued and partial data and resets both slots and overflow. In the next cycle rd_valid is 0 and svc_req is 1, and the next packet loaded fills from byte 0.
- R10: pkt_sent while rd_valid is 0 has no effect.
- R11: A packet closing in the same cycle as pkt_sent releases the head leaves the queued-packet count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load wr_data into the current slot |
| wr_data | input | 8 | Byte to load |
| short_pkt | input | 1 | Close the current slot at its present length |
| flush | input | 1 | Discard all data, reset slots and overflow |
| pkt_sent | input | 1 | Head packet has been transmitted; release it |
| rd_addr | input | 6 | Byte index within the head packet |
| rd_valid | output | 1 | A complete packet is queued |
| rd_len | output | 7 | Length of the head packet, 0 to 64 |
| rd_data | output | 8 | Byte rd_addr of the head packet |
| svc_req | output | 1 | One or fewer complete packets queued |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
A wrong packet count shows in the cycle after the faulty edge. svc_req falls early or late, or rd_valid stays high after the last pkt_sent. A wrong fill index or slot pointer does not show up at once. It appears only when the head packet is read back, as a wrong rd_len or bytes in the wrong order or slot. For that reason every packet the scoreboard queues is read byte by byte before it is released. A lost flush or overflow reset shows on the first cycle after the flush, and any stale fill index shows on the first packet loaded after it.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Ping-pong successor of a slot index.
  function automatic int next_slot(input int cur, input int n_slots);
    return (cur + 1 == n_slots) ? 0 : cur + 1;
  endfunction

  // Length a slot takes when it closes: bytes held plus any byte written now.
  function automatic int closing_length(input int held, input bit wr_now);
    return held + (wr_now ? 1 : 0);
  endfunction

  // Whether this cycle's write fills the slot to its capacity.
  function automatic bit fills_slot(input int held, input bit wr_now, input int cap);
    return wr_now && (held + 1 == cap);
  endfunction

endpackage

// File: rtl/txq_fill_ctrl.sv
module txq_fill_ctrl #(
  parameter int PKT_BYTES = 64,
  parameter int SLOTS     = 2,
  localparam int AW = $clog2(PKT_BYTES),
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int PW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          short_pkt,
  input  logic          slot_free,
  output logic [PW-1:0] wr_slot,
  output logic [AW-1:0] wr_idx,
  output logic          wr_accept,
  output logic          close_evt,
  output logic [LW-1:0] close_len,
  output logic          drop_evt
);
  import txq_pkg::*;

  logic [LW-1:0] fill;

  assign wr_accept = wr_en & slot_free & ~flush;
  assign drop_evt  = wr_en & ~slot_free & ~flush;
  assign close_evt = ~flush & slot_free &
                     (fills_slot(int'(fill), wr_accept, PKT_BYTES) | short_pkt);
  assign close_len = LW'(closing_length(int'(fill), wr_accept));
  assign wr_idx    = fill[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill    <= '0;
      wr_slot <= '0;
    end else if (flush) begin
      fill    <= '0;
      wr_slot <= '0;
    end else if (close_evt) begin
      fill    <= '0;
      wr_slot <= PW'(next_slot(int'(wr_slot), SLOTS));
    end else if (wr_accept) begin
      fill    <= fill + LW'(1);
    end
  end

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill < LW'(PKT_BYTES));

  // R9
  flush_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0) && (wr_slot == '0));

endmodule

// File: rtl/txq_slot_mem.sv
module txq_slot_mem #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 64,
  parameter int SLOTS     = 2,
  localparam int AW = $clog2(PKT_BYTES),
  localparam int PW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              wr_accept,
  input  logic [PW-1:0]     wr_slot,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     rd_slot,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_out [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] bytes_q [PKT_BYTES];
    logic              we;

    assign we = wr_accept && (wr_slot == PW'(s));

    always_ff @(posedge clk) begin
      if (we) bytes_q[wr_idx] <= wr_data;
    end

    assign slot_out[s] = bytes_q[rd_addr];
  end

  assign rd_data = slot_out[rd_slot];

endmodule

// File: rtl/txq_queue_ctrl.sv
module txq_queue_ctrl #(
  parameter int PKT_BYTES = 64,
  parameter int SLOTS     = 2,
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int PW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pkt_sent,
  input  logic          close_evt,
  input  logic [LW-1:0] close_len,
  input  logic [PW-1:0] wr_slot,
  input  logic          drop_evt,
  output logic [PW-1:0] rd_slot,
  output logic          slot_free,
  output logic          rd_valid,
  output logic [LW-1:0] rd_len,
  output logic          svc_req,
  output logic          overflow
);
  import txq_pkg::*;

  logic [CW-1:0] count;
  logic [LW-1:0] len_q [SLOTS];
  logic          send_evt;

  assign send_evt  = pkt_sent & (count != '0) & ~flush;
  assign slot_free = count < CW'(SLOTS);
  assign rd_valid  = count != '0;
  assign svc_req   = count <= CW'(SLOTS - 1);
  assign rd_len    = len_q[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      rd_slot  <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      count    <= '0;
      rd_slot  <= '0;
      overflow <= 1'b0;
    end else begin
      if (close_evt && !send_evt)      count <= count + CW'(1);
      else if (send_evt && !close_evt) count <= count - CW'(1);
      if (send_evt) rd_slot <= PW'(next_slot(int'(rd_slot), SLOTS));
      if (drop_evt) overflow <= 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                len_q[s] <= '0;
      else if (flush)                            len_q[s] <= '0;
      else if (close_evt && wr_slot == PW'(s))   len_q[s] <= close_len;
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(SLOTS));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && !overflow);

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overflow);

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);

  // R11
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && send_evt) |=> (count == $past(count)));

  // R10
  idle_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && count == '0 && !close_evt) |=> (count == '0) && $stable(rd_slot));

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len <= LW'(PKT_BYTES)));

endmodule

// File: rtl/bulkin_txq.sv
module bulkin_txq #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 64,
  parameter int SLOTS     = 2,
  localparam int AW = $clog2(PKT_BYTES),
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int PW = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              short_pkt,
  input  logic              flush,
  input  logic              pkt_sent,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [LW-1:0]     rd_len,
  output logic [DATA_W-1:0] rd_data,
  output logic              svc_req,
  output logic              overflow
);
  logic [PW-1:0] wr_slot;
  logic [PW-1:0] rd_slot;
  logic [AW-1:0] wr_idx;
  logic [LW-1:0] close_len;
  logic          wr_accept;
  logic          close_evt;
  logic          drop_evt;
  logic          slot_free;

  txq_fill_ctrl #(.PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS)) u_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
    .short_pkt(short_pkt), .slot_free(slot_free), .wr_slot(wr_slot),
    .wr_idx(wr_idx), .wr_accept(wr_accept), .close_evt(close_evt),
    .close_len(close_len), .drop_evt(drop_evt)
  );

  txq_slot_mem #(.DATA_W(DATA_W), .PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS)) u_mem (
    .clk(clk), .wr_accept(wr_accept), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  txq_queue_ctrl #(.PKT_BYTES(PKT_BYTES), .SLOTS(SLOTS)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_sent(pkt_sent),
    .close_evt(close_evt), .close_len(close_len), .wr_slot(wr_slot),
    .drop_evt(drop_evt), .rd_slot(rd_slot), .slot_free(slot_free),
    .rd_valid(rd_valid), .rd_len(rd_len), .svc_req(svc_req),
    .overflow(overflow)
  );

  // R8
  no_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !wr_accept);

  // R5
  partial_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !close_evt && !flush) |=> !rd_valid);

endmodule

// File: tb/bulkin_txq_test.sv
module bulkin_txq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       short_pkt = 1'b0;
  logic       flush = 1'b0;
  logic       pkt_sent = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       rd_valid;
  logic [6:0] rd_len;
  logic [7:0] rd_data;
  logic       svc_req;
  logic       overflow;

  int checks = 0;
  int fails  = 0;

  int         exp_len[$];
  logic [7:0] exp_bytes[$];

  bulkin_txq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .short_pkt(short_pkt), .flush(flush), .pkt_sent(pkt_sent),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_len(rd_len),
    .rd_data(rd_data), .svc_req(svc_req), .overflow(overflow)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0; short_pkt = 1'b0; flush = 1'b0; pkt_sent = 1'b0;
  endtask

  // Driver: load n bytes from seed, optionally closing with short on the last one.
  // A closed packet is pushed to the scoreboard.
  task automatic load(input int n, input int seed, input bit close_short, input bit expect_store);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1;
      wr_data = 8'(seed + i);
      if (close_short && i == n - 1) short_pkt = 1'b1;
      if (expect_store) exp_bytes.push_back(8'(seed + i));
      tick();
    end
    if (expect_store && (close_short || n == 64)) exp_len.push_back(n);
  endtask

  task automatic mark_short_empty();
    short_pkt = 1'b1;
    exp_len.push_back(0);
    tick();
  endtask

  // Monitor: pop the expected head and compare length and every byte, then release.
  task automatic drain(input string req);
    int n;
    int bad;
    logic [7:0] e;
    n = exp_len.pop_front();
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(int'(rd_len) == n, req, int'(rd_len), n);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      rd_addr = 6'(i);
      #1;
      e = exp_bytes.pop_front();
      if (rd_data !== e && bad == 0) begin
        bad = 1;
        chk(1'b0, req, int'(rd_data), int'(e));
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
    pkt_sent = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(svc_req == 1'b1, "R1 svc", int'(svc_req), 1);
    chk(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    chk(overflow == 1'b0, "R1 ovf", int'(overflow), 0);
    rst_n = 1'b1;
    tick();

    // R5 partial slot is hidden
    load(9, 8'h10, 1'b0, 1'b1);
    chk(rd_valid == 1'b0, "R5 valid", int'(rd_valid), 0);
    chk(svc_req == 1'b1, "R5 svc", int'(svc_req), 1);
    // R3 short closes with the byte written alongside it (10 total)
    load(1, 8'h19, 1'b1, 1'b1);
    exp_len.pop_back();
    exp_len.push_back(10);
    chk(rd_valid == 1'b1, "R3 valid", int'(rd_valid), 1);
    chk(int'(rd_len) == 10, "R3 len", int'(rd_len), 10);
    chk(svc_req == 1'b1, "R6 one queued svc", int'(svc_req), 1);

    // R2 full 64-byte packet
    load(64, 8'h80, 1'b0, 1'b1);
    chk(svc_req == 1'b0, "R6 two queued svc", int'(svc_req), 0);

    // R8 writes while full are dropped
    load(3, 8'hEE, 1'b0, 1'b0);
    chk(overflow == 1'b1, "R8 ovf", int'(overflow), 1);
    short_pkt = 1'b1;
    tick();
    chk(int'(rd_len) == 10, "R8 head unchanged", int'(rd_len), 10);

    // R7 oldest first, data order, release
    drain("R7 first");
    chk(svc_req == 1'b1, "R7 svc after send", int'(svc_req), 1);
    chk(overflow == 1'b1, "R8 sticky", int'(overflow), 1);
    drain("R2 full packet");
    chk(rd_valid == 1'b0, "R7 empty", int'(rd_valid), 0);

    // R10 sent while empty ignored
    pkt_sent = 1'b1;
    tick();
    chk(rd_valid == 1'b0, "R10 valid", int'(rd_valid), 0);
    chk(svc_req == 1'b1, "R10 svc", int'(svc_req), 1);

    // R4 zero-length packet
    mark_short_empty();
    chk(rd_valid == 1'b1, "R4 valid", int'(rd_valid), 1);
    chk(int'(rd_len) == 0, "R4 len", int'(rd_len), 0);
    drain("R4 drain");
    chk(rd_valid == 1'b0, "R10 count intact", int'(rd_valid), 0);

    // R11 close and send in the same cycle
    load(64, 8'h40, 1'b0, 1'b1);
    load(63, 8'hC0, 1'b0, 1'b1);
    wr_en = 1'b1; wr_data = 8'(8'hC0 + 63); exp_bytes.push_back(8'(8'hC0 + 63));
    pkt_sent = 1'b1;
    exp_len.push_back(64);
    for (int i = 0; i < 64; i++) void'(exp_bytes.pop_front());
    void'(exp_len.pop_front());
    tick();
    chk(rd_valid == 1'b1, "R11 valid", int'(rd_valid), 1);
    chk(svc_req == 1'b1, "R11 svc", int'(svc_req), 1);
    drain("R11 new head");
    chk(rd_valid == 1'b0, "R11 empty", int'(rd_valid), 0);

    // R9 flush discards full, partial and overflow
    load(64, 8'h01, 1'b0, 1'b0);
    load(64, 8'h02, 1'b0, 1'b0);
    load(1, 8'h03, 1'b0, 1'b0);
    chk(overflow == 1'b1, "R8 ovf again", int'(overflow), 1);
    flush = 1'b1;
    tick();
    chk(rd_valid == 1'b0, "R9 valid", int'(rd_valid), 0);
    chk(svc_req == 1'b1, "R9 svc", int'(svc_req), 1);
    chk(overflow == 1'b0, "R9 ovf", int'(overflow), 0);
    load(5, 8'h70, 1'b1, 1'b1);
    drain("R9 refill from byte 0");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule